// File: doc/BRIEF.md
# Buffered Channel and Reference Selection

This block keeps the channel and reference selection that the analog multiplexer sees stable for the whole sampling window of a conversion. The CPU writes a holding register at any time, and reads it back whenever it likes. While no conversion is running, the live selection follows the holding register. A conversion-start pulse freezes it. A near-completion pulse from the conversion sequencer releases it one converter clock before the result is flagged, so a selection written during the conversion is applied in time for the next one.

A change of the reference field, or a move of the live channel onto a differential channel, needs settling time in the gain stage. The block measures that time with a down-counter that counts converter clock ticks. A differential conversion that starts before the counter reaches zero has its result-valid qualifier cleared. The qualifier is captured at each start and held until the next start.

Top module: `chansel_buffer`

## Requirements
- R1: After reset the holding register, the live channel, the live reference and `result_valid` are all zero, and no settling interval is pending.
- R2: A write with `cpu_wr_en` loads `cpu_wr_data` into the holding register. The reference field is in the upper REF_W bits and the channel is in the lower CH_W bits. `cpu_rd_data` shows the new value from the next cycle on.
- R3: While no conversion is in progress, the live channel and live reference equal the holding register one cycle after any write.
- R4: At the clock edge that closes a cycle with `conv_start` high, the live selection takes the holding register value, including a write made in that same cycle. After that edge, writes leave the live selection unchanged until the release.
- R5: At the clock edge that closes a cycle with `conv_near_done` high, the live selection takes the holding register value, and tracking continues from then on unless a start arrives in the same cycle.
- R6: When the live channel changes to a different channel code of DIFF_BASE or above (a differential channel), the settling counter reloads to SETTLE_TICKS.
- R7: When the live reference field changes, the settling counter reloads to SETTLE_TICKS, whatever the channel type.
- R8: At each start, `result_valid` becomes 0 if the captured channel is differential and the settling count after that edge is nonzero. Otherwise it becomes 1. It holds its value until the next start.
- R9: The settling counter decrements by one only on cycles with `tick` high. It holds on all other cycles, so the interval is measured in converter clock ticks and not in system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per converter clock period |
| cpu_wr_en | input | 1 | Write strobe for the holding register |
| cpu_wr_data | input | REF_W+CH_W | Write data: {reference, channel} |
| cpu_rd_data | output | REF_W+CH_W | Holding register readback |
| conv_start | input | 1 | Conversion starts at the edge closing this cycle |
| conv_near_done | input | 1 | Last converter cycle before completion |
| live_chan | output | CH_W | Channel driving the multiplexer |
| live_ref | output | REF_W | Reference driving the converter |
| result_valid | output | 1 | Qualifier for the result of the current conversion |

## Verification
A frozen state that never releases shows up at `live_chan` right after the first `conv_near_done`: the port keeps the old value while readback shows a new one. A lock that fails to hold shows up one cycle after any write made during a conversion. A settling counter that reloads wrongly or counts the wrong events cannot be seen directly. It shows up only at the next differential start, as a `result_valid` value that disagrees with the tick count since the last reference or differential change. For that reason the bench compares every output on every cycle against a model, across long runs with sparse ticks.

// File: rtl/csb_pkg.sv
package csb_pkg;
  typedef enum logic {
    PH_TRACK = 1'b0,
    PH_HOLD  = 1'b1
  } sel_phase_e;
endpackage

// File: rtl/csb_hold_reg.sv
module csb_hold_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] hold_nx
);
  always_comb begin
    hold_nx = hold_q;
    if (wr_en) hold_nx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (wr_en) hold_q <= hold_nx;
  end
endmodule

// File: rtl/csb_live_sel.sv
module csb_live_sel
  import csb_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int REF_W     = 2,
  parameter int DIFF_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             conv_near_done,
  input  logic [CH_W-1:0]  src_chan,
  input  logic [REF_W-1:0] src_ref,
  output logic [CH_W-1:0]  live_chan,
  output logic [REF_W-1:0] live_ref,
  output logic [CH_W-1:0]  chan_nx,
  output logic             settle_reload,
  output sel_phase_e       phase_q
);
  localparam logic [CH_W-1:0] DIFF_LO = CH_W'(DIFF_BASE);

  sel_phase_e       phase_nx;
  logic             upd_en;
  logic [REF_W-1:0] ref_nx;
  logic             chan_moved, ref_moved;

  always_comb begin
    upd_en = (phase_q == PH_TRACK) || conv_near_done || conv_start;
    chan_nx = live_chan;
    ref_nx  = live_ref;
    if (upd_en) begin
      chan_nx = src_chan;
      ref_nx  = src_ref;
    end
    chan_moved    = (chan_nx != live_chan) && (chan_nx >= DIFF_LO);
    ref_moved     = (ref_nx != live_ref);
    settle_reload = upd_en && (chan_moved || ref_moved);

    phase_nx = phase_q;
    if (conv_start)          phase_nx = PH_HOLD;
    else if (conv_near_done) phase_nx = PH_TRACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_chan <= '0;
      live_ref  <= '0;
      phase_q   <= PH_TRACK;
    end else begin
      phase_q <= phase_nx;
      if (upd_en) begin
        live_chan <= chan_nx;
        live_ref  <= ref_nx;
      end
    end
  end
endmodule

// File: rtl/csb_settle_timer.sv
module csb_settle_timer #(
  parameter int SETTLE_TICKS = 250,
  localparam int CNT_W = $clog2(SETTLE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_TICKS);

  logic cnt_en;

  always_comb begin
    cnt_en = reload || (tick && (cnt_q != '0));
    cnt_nx = cnt_q;
    if (reload)      cnt_nx = LOAD_VAL;
    else if (cnt_en) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/chansel_buffer.sv
module chansel_buffer
  import csb_pkg::*;
#(
  parameter int CH_W         = 5,
  parameter int REF_W        = 2,
  parameter int DIFF_BASE    = 16,
  parameter int SETTLE_TICKS = 250,
  localparam int SEL_W = CH_W + REF_W,
  localparam int CNT_W = $clog2(SETTLE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cpu_wr_en,
  input  logic [SEL_W-1:0] cpu_wr_data,
  output logic [SEL_W-1:0] cpu_rd_data,
  input  logic             conv_start,
  input  logic             conv_near_done,
  output logic [CH_W-1:0]  live_chan,
  output logic [REF_W-1:0] live_ref,
  output logic             result_valid
);
  localparam logic [CH_W-1:0] DIFF_LO = CH_W'(DIFF_BASE);

  logic [SEL_W-1:0] hold_q, hold_nx;
  logic [CH_W-1:0]  chan_nx;
  logic             settle_reload;
  sel_phase_e       phase_q;
  logic [CNT_W-1:0] settle_cnt, settle_nx;
  logic             valid_nx;

  csb_hold_reg #(.W(SEL_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr_en),
    .wr_data (cpu_wr_data),
    .hold_q  (hold_q),
    .hold_nx (hold_nx)
  );

  csb_live_sel #(.CH_W(CH_W), .REF_W(REF_W), .DIFF_BASE(DIFF_BASE)) u_live (
    .clk            (clk),
    .rst_n          (rst_n),
    .conv_start     (conv_start),
    .conv_near_done (conv_near_done),
    .src_chan       (hold_nx[CH_W-1:0]),
    .src_ref        (hold_nx[SEL_W-1:CH_W]),
    .live_chan      (live_chan),
    .live_ref       (live_ref),
    .chan_nx        (chan_nx),
    .settle_reload  (settle_reload),
    .phase_q        (phase_q)
  );

  csb_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .reload (settle_reload),
    .cnt_q  (settle_cnt),
    .cnt_nx (settle_nx)
  );

  always_comb begin
    valid_nx = result_valid;
    if (conv_start) valid_nx = !((chan_nx >= DIFF_LO) && (settle_nx != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          result_valid <= 1'b0;
    else if (conv_start) result_valid <= valid_nx;
  end

  assign cpu_rd_data = hold_q;
endmodule

// File: rtl/csb_chk.sv
module csb_chk
  import csb_pkg::*;
#(
  parameter int CH_W         = 5,
  parameter int REF_W        = 2,
  parameter int DIFF_BASE    = 16,
  parameter int SETTLE_TICKS = 250,
  localparam int SEL_W = CH_W + REF_W,
  localparam int CNT_W = $clog2(SETTLE_TICKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cpu_wr_en,
  input logic             conv_start,
  input logic             conv_near_done,
  input logic [SEL_W-1:0] cpu_rd_data,
  input logic [CH_W-1:0]  live_chan,
  input logic [REF_W-1:0] live_ref,
  input logic             result_valid,
  input sel_phase_e       phase_q,
  input logic [CNT_W-1:0] settle_cnt
);
  // R3
  idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TRACK && !cpu_wr_en) |=> ({live_ref, live_chan} == cpu_rd_data));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && !conv_near_done && !conv_start) |=> ($stable(live_chan) && $stable(live_ref)));

  // R7
  ref_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_ref) |-> (settle_cnt == CNT_W'(SETTLE_TICKS)));

  // R8
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (result_valid == !((live_chan >= CH_W'(DIFF_BASE)) && (settle_cnt != '0))));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (settle_cnt == $past(settle_cnt) || settle_cnt == CNT_W'(SETTLE_TICKS)));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_cnt <= CNT_W'(SETTLE_TICKS));
endmodule

bind chansel_buffer csb_chk #(
  .CH_W(CH_W), .REF_W(REF_W), .DIFF_BASE(DIFF_BASE), .SETTLE_TICKS(SETTLE_TICKS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .cpu_wr_en      (cpu_wr_en),
  .conv_start     (conv_start),
  .conv_near_done (conv_near_done),
  .cpu_rd_data    (cpu_rd_data),
  .live_chan      (live_chan),
  .live_ref       (live_ref),
  .result_valid   (result_valid),
  .phase_q        (phase_q),
  .settle_cnt     (settle_cnt)
);

// File: tb/chansel_buffer_tb.sv
module chansel_buffer_tb;
  localparam int CH_W = 5;
  localparam int REF_W = 2;
  localparam int DB = 16;
  localparam int ST = 12;
  localparam int SW = CH_W + REF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, wr, st, nd;
  logic [SW-1:0] wd, rd;
  logic [CH_W-1:0] lch;
  logic [REF_W-1:0] lref;
  logic vld;

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [SW-1:0] m_hold, m_live;
  logic m_busy, m_valid;
  int m_cnt;

  always #10 clk = ~clk;

  chansel_buffer #(.CH_W(CH_W), .REF_W(REF_W), .DIFF_BASE(DB), .SETTLE_TICKS(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_wr_en(wr), .cpu_wr_data(wd),
    .cpu_rd_data(rd), .conv_start(st), .conv_near_done(nd),
    .live_chan(lch), .live_ref(lref), .result_valid(vld)
  );

  function automatic bit is_diff(input logic [SW-1:0] s);
    return int'(s[CH_W-1:0]) >= DB;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic w, input logic [SW-1:0] d, input logic s,
                            input logic n, input logic t);
    logic [SW-1:0] hn, ln;
    bit upd, rl;
    hn = w ? d : m_hold;
    upd = !m_busy || n || s;
    ln = upd ? hn : m_live;
    rl = upd && (((ln[CH_W-1:0] != m_live[CH_W-1:0]) && is_diff(ln)) ||
                 (ln[SW-1:CH_W] != m_live[SW-1:CH_W]));
    if (rl) m_cnt = ST;
    else if (t && m_cnt != 0) m_cnt = m_cnt - 1;
    if (s) m_valid = !(is_diff(ln) && m_cnt != 0);
    m_busy = s ? 1'b1 : (n ? 1'b0 : m_busy);
    m_hold = hn;
    m_live = ln;
  endtask

  task automatic step(input logic w, input logic [SW-1:0] d, input logic s,
                      input logic n, input logic t);
    wr = w; wd = d; st = s; nd = n; tick = t;
    @(posedge clk);
    model_edge(w, d, s, n, t);
    @(negedge clk);
    wr = 1'b0; st = 1'b0; nd = 1'b0; tick = 1'b0;
  endtask

  task automatic cmp_all();
    chk("R2 readback", int'(rd), int'(m_hold));
    chk("R3/R4/R5 live", int'({lref, lch}), int'(m_live));
    chk("R8 valid", int'(vld), int'(m_valid));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wr = 0; wd = '0; st = 0; nd = 0; tick = 0;
    m_hold = '0; m_live = '0; m_busy = 0; m_valid = 0; m_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 readback", int'(rd), 0);
    chk("R1 live", int'({lref, lch}), 0);
    chk("R1 valid", int'(vld), 0);

    // R2, R3: idle write tracked next cycle
    step(1, {2'd0, 5'd3}, 0, 0, 0);
    chk("R2 readback", int'(rd), 3);
    chk("R3 live follows", int'(lch), 3);

    // R4: write in start cycle is captured
    step(1, {2'd0, 5'd5}, 1, 0, 0);
    chk("R4 same-cycle capture", int'(lch), 5);
    chk("R8 single-ended valid", int'(vld), 1);

    // R4: write while busy does not reach live
    step(1, {2'd0, 5'd7}, 0, 0, 0);
    chk("R2 readback busy", int'(rd), 7);
    chk("R4 locked", int'(lch), 5);
    step(0, '0, 0, 0, 1);
    chk("R4 still locked", int'(lch), 5);

    // R5: release on near-done
    step(0, '0, 0, 1, 0);
    chk("R5 release", int'(lch), 7);

    // R6, R8: differential selection then immediate start
    step(1, {2'd0, 5'd20}, 0, 0, 0);
    step(0, '0, 1, 0, 1);
    chk("R6 diff reload invalid", int'(vld), 0);
    step(0, '0, 0, 1, 0);
    for (int i = 0; i < ST - 1; i++) step(0, '0, 0, 0, 1);
    step(0, '0, 1, 0, 0);
    chk("R8 settled valid", int'(vld), 1);
    step(0, '0, 0, 1, 0);

    // R9: no ticks, counter must not advance
    step(1, {2'd0, 5'd21}, 0, 0, 0);
    for (int i = 0; i < 3 * ST; i++) step(0, '0, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R9 no tick no drain", int'(vld), 0);
    step(0, '0, 0, 1, 0);
    for (int i = 0; i < ST; i++) step(0, '0, 0, 0, 1);

    // R7: reference change on same differential channel
    step(1, {2'd1, 5'd21}, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R7 ref reload invalid", int'(vld), 0);
    step(0, '0, 0, 1, 0);
    cmp_all();

    // constrained random against model
    for (int i = 0; i < 4000; i++) begin
      logic w, s, n, t;
      logic [SW-1:0] d;
      w = ($urandom % 5) == 0;
      d[CH_W-1:0] = CH_W'($urandom);
      d[SW-1:CH_W] = (($urandom % 6) == 0) ? REF_W'($urandom) : m_hold[SW-1:CH_W];
      t = ($urandom % 3) == 0;
      n = m_busy && (($urandom % 8) == 0);
      s = m_busy ? (n && ($urandom % 2 == 0)) : (($urandom % 10) == 0);
      step(w, d, s, n, t);
      cmp_all();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule